// File: doc/BRIEF.md
# UART FIFO Status Flags and Interrupt Requests

This block holds the status flags and the interrupt-request logic of a UART whose transmit and receive paths are buffered by FIFOs. The FIFOs, the shifters and the baud generator sit elsewhere. This block sees them only as inputs: the current fill levels, the programmed trigger thresholds, a pulse each time a byte leaves the transmit FIFO for the shifter, a pulse each time a received character arrives, and pulses for line errors, breaks and overruns.

Software reaches the block through a small register port with two locations, a control register and a status register. The block drives four level-sensitive interrupt requests: transmit-empty, receive-full, receive-error and break. A flag can only be cleared by a status write of zero that follows a status read in which that flag was seen as one. The block also passes a transmit-FIFO write on as a start pulse only while transmission is enabled.

Top module: `fifo_uart_irq`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0x00, all four interrupt outputs are 0 and `tx_start` is 0.
- R2: `reg_sel` = 0 selects the control register and `reg_sel` = 1 selects the status register, and `reg_rdata` shows the selected register with no delay. Control bit 7 is the transmit interrupt enable, bit 6 the receive interrupt enable, bit 5 the transmit enable and bit 3 the receive-error interrupt enable. All other control bits read 0. Status bit 0 is data-ready, bit 1 receive-full, bit 2 overrun, bit 3 break, bit 4 line error and bit 5 transmit-empty. Status bits 7:6 read 0.
- R3: A `tx_pop` pulse sets the transmit-empty flag at the next edge when `tx_level` <= `tx_trig`, including when they are equal. It leaves the flag unchanged when `tx_level` > `tx_trig`.
- R4: `irq_txe` is 1 exactly when the transmit-empty flag and the transmit interrupt enable are both 1, and it follows a change of the enable in the same cycle.
- R5: `irq_rxf` is 1 when the receive interrupt enable is 1 and either the receive-full flag or the data-ready flag is 1.
- R6: The receive-full flag is set at every edge where `rx_level` >= `rx_trig`.
- R7: With 0 < `rx_level` < `rx_trig`, the data-ready flag sets at the `idle_limit`-th edge after the last `rx_push` edge, and not earlier.
- R8: `irq_rxerr` follows the line-error flag and `irq_brk` follows the break flag or the overrun flag. Both requests are masked only when the receive interrupt enable and the receive-error interrupt enable are both 0.
- R9: A flag clears only on a status write whose bit for it is 0, and only when a status read since the last status write returned that flag as 1. A write of 0 with no such read, or a write of 1, leaves the flag set.
- R10: A set event in the same cycle as a valid clear wins, and the flag stays 1.
- R11: `tx_start` is 1 only in a cycle where `tx_wr` is 1 and the transmit enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_rd | input | 1 | Read strobe (status reads arm clearing) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| tx_wr | input | 1 | Software write into the transmit FIFO |
| tx_pop | input | 1 | Byte moved from transmit FIFO to shifter |
| tx_level | input | CNT_W | Transmit FIFO level after the pop |
| tx_trig | input | CNT_W | Transmit trigger threshold |
| rx_push | input | 1 | New character entered the receive FIFO |
| rx_level | input | CNT_W | Receive FIFO level |
| rx_trig | input | CNT_W | Receive trigger threshold |
| idle_limit | input | IDLE_W | Idle cycles before data-ready sets |
| rx_err_evt | input | 1 | Line error event |
| rx_brk_evt | input | 1 | Break detected event |
| rx_ovr_evt | input | 1 | Receive overrun event |
| tx_start | output | 1 | Gated transmission start pulse |
| irq_txe | output | 1 | Transmit-empty interrupt request |
| irq_rxf | output | 1 | Receive-full interrupt request |
| irq_rxerr | output | 1 | Receive-error interrupt request |
| irq_brk | output | 1 | Break interrupt request |

## Verification
The two functions that can land in the same cycle are a software clear and a hardware set of one flag. The bench reads the status register so that the line-error flag is armed. It then issues the clearing write of zero while it pulses `rx_err_evt` in the same cycle. The flag must still read 1 afterwards, and because that write used up the read, a second bare write of zero must also leave it set. The flag is cleared only after a fresh read followed by a write.

// File: rtl/fuir_pkg.sv
// Package: shared widths and bit positions for the UART flag/interrupt unit.
// Assumes: an 8-bit register port and six status flags.
package fuir_pkg;
    localparam int REG_W  = 8;
    localparam int NFLAG  = 6;
    // status flag bit positions
    localparam int FL_DR   = 0;
    localparam int FL_RDF  = 1;
    localparam int FL_ORER = 2;
    localparam int FL_BRK  = 3;
    localparam int FL_ER   = 4;
    localparam int FL_TXE  = 5;
    // control bit positions
    localparam int CB_REIE = 3;
    localparam int CB_TE   = 5;
    localparam int CB_RIE  = 6;
    localparam int CB_TIE  = 7;
    localparam logic [REG_W-1:0] CTRL_MASK = 8'hE8;
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_STAT = 1'b1;
endpackage

// File: rtl/fuir_ctrl_reg.sv
// Control register: holds the enable bits and drops unimplemented bits.
// Assumes: writes are single-cycle strobes; unimplemented bits read 0.
module fuir_ctrl_reg
    import fuir_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl_q
);
    // Capture the implemented enable bits on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wdata & CTRL_MASK;
    end
endmodule

// File: rtl/fuir_flag_bank.sv
// Flag bank: one sticky flag per status bit. Each flag has an arm bit that is
// set by a read which saw the flag as 1. A later write of 0 clears the flag
// only while it is armed. A set event beats a clear in the same cycle.
// Assumes: rd_en/wr_en are already qualified to the status location.
module fuir_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         rd_en,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;
        logic armed_q;
        logic clr;

        assign clr = wr_en && !wdata[i] && armed_q;

        // Hold the flag; hardware set has priority over a software clear.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= set_vec[i] | (flag_q & ~clr);
        end

        // Arm on a read that returns 1; any status write consumes the arm.
        always_ff @(posedge clk) begin
            if (!rst_n)                armed_q <= 1'b0;
            else if (wr_en)            armed_q <= 1'b0;
            else if (rd_en && flag_q)  armed_q <= 1'b1;
        end

        assign flags[i] = flag_q;
    end
endmodule

// File: rtl/fuir_idle_timer.sv
// Idle timer: counts cycles without a new character while the receive FIFO
// holds data below its trigger, and raises a one-cycle set for data-ready
// on the edge where the count reaches idle_limit.
// Assumes: idle_limit >= 1 (0 disables the timeout).
module fuir_idle_timer #(
    parameter int CNT_W  = 5,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  rx_trig,
    input  logic              rx_push,
    input  logic [IDLE_W-1:0] idle_limit,
    output logic              dr_set
);
    logic              waiting;
    logic [IDLE_W-1:0] cnt_q;
    logic [IDLE_W:0]   cnt_inc;

    assign waiting = (rx_level != '0) && (rx_level < rx_trig);
    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign dr_set  = waiting && !rx_push && (cnt_inc == {1'b0, idle_limit});

    // Restart on arrival or leaving the waiting window; saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (rx_push || !waiting)  cnt_q <= '0;
        else if (cnt_q != idle_limit)  cnt_q <= cnt_inc[IDLE_W-1:0];
    end
endmodule

// File: rtl/fifo_uart_irq.sv
// Top: status flags, enables, clear sequencing, interrupt requests and
// transmit start gating of a FIFO-buffered UART.
// Assumes: FIFO levels, triggers and line events come from neighbouring
// logic in the same clock domain; the interrupt outputs are combinational levels.
module fifo_uart_irq
    import fuir_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              tx_wr,
    input  logic              tx_pop,
    input  logic [CNT_W-1:0]  tx_level,
    input  logic [CNT_W-1:0]  tx_trig,
    input  logic              rx_push,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  rx_trig,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              rx_err_evt,
    input  logic              rx_brk_evt,
    input  logic              rx_ovr_evt,
    output logic              tx_start,
    output logic              irq_txe,
    output logic              irq_rxf,
    output logic              irq_rxerr,
    output logic              irq_brk
);
    localparam int PAD_W = REG_W - NFLAG;

    logic [REG_W-1:0] ctrl_q;
    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] set_vec;
    logic             dr_set;
    logic             rx_any_en;

    fuir_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr && reg_sel == SEL_CTRL),
        .wdata  (reg_wdata),
        .ctrl_q (ctrl_q)
    );

    fuir_idle_timer #(.CNT_W(CNT_W), .IDLE_W(IDLE_W)) u_idle (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_level   (rx_level),
        .rx_trig    (rx_trig),
        .rx_push    (rx_push),
        .idle_limit (idle_limit),
        .dr_set     (dr_set)
    );

    // Gather the hardware set events by status bit position.
    always_comb begin
        set_vec          = '0;
        set_vec[FL_DR]   = dr_set;
        set_vec[FL_RDF]  = rx_level >= rx_trig;
        set_vec[FL_ORER] = rx_ovr_evt;
        set_vec[FL_BRK]  = rx_brk_evt;
        set_vec[FL_ER]   = rx_err_evt;
        set_vec[FL_TXE]  = tx_pop && (tx_level <= tx_trig);
    end

    fuir_flag_bank #(.N(NFLAG)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .rd_en   (reg_rd && reg_sel == SEL_STAT),
        .wr_en   (reg_wr && reg_sel == SEL_STAT),
        .wdata   (reg_wdata[NFLAG-1:0]),
        .flags   (flags_q)
    );

    // Read mux for the two register locations.
    always_comb begin
        if (reg_sel == SEL_CTRL) reg_rdata = ctrl_q;
        else                     reg_rdata = {{PAD_W{1'b0}}, flags_q};
    end

    // Level interrupt requests and start gating, recomputed every cycle.
    always_comb begin
        rx_any_en = ctrl_q[CB_RIE] | ctrl_q[CB_REIE];
        irq_txe   = flags_q[FL_TXE] & ctrl_q[CB_TIE];
        irq_rxf   = (flags_q[FL_RDF] | flags_q[FL_DR]) & ctrl_q[CB_RIE];
        irq_rxerr = flags_q[FL_ER] & rx_any_en;
        irq_brk   = (flags_q[FL_BRK] | flags_q[FL_ORER]) & rx_any_en;
        tx_start  = tx_wr & ctrl_q[CB_TE];
    end
endmodule

// File: rtl/fuir_checker.sv
// Checker: temporal properties of the flag/interrupt unit, bound to the top.
module fuir_checker
    import fuir_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_sel,
    input logic             reg_wr,
    input logic             tx_wr,
    input logic             tx_pop,
    input logic [CNT_W-1:0] tx_level,
    input logic [CNT_W-1:0] tx_trig,
    input logic [CNT_W-1:0] rx_level,
    input logic [CNT_W-1:0] rx_trig,
    input logic             rx_err_evt,
    input logic             tx_start,
    input logic             irq_txe,
    input logic             irq_rxf,
    input logic             irq_rxerr,
    input logic             irq_brk,
    input logic [REG_W-1:0] ctrl_q,
    input logic [NFLAG-1:0] flags_q
);
    AST_TXE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_level <= tx_trig) |=> flags_q[FL_TXE]); // R3
    AST_TX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CB_TIE] |-> !irq_txe); // R4
    AST_RXF_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[CB_RIE] |-> !irq_rxf); // R5
    AST_RDF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level >= rx_trig) |=> flags_q[FL_RDF]); // R6
    AST_ERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CB_RIE] && !ctrl_q[CB_REIE]) |-> (!irq_rxerr && !irq_brk)); // R8
    AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags_q) & ~flags_q)) |-> ($past(reg_wr) && $past(reg_sel) == SEL_STAT)); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err_evt |=> flags_q[FL_ER]); // R10
    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> (tx_wr && ctrl_q[CB_TE])); // R11
endmodule

bind fifo_uart_irq fuir_checker #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .tx_wr      (tx_wr),
    .tx_pop     (tx_pop),
    .tx_level   (tx_level),
    .tx_trig    (tx_trig),
    .rx_level   (rx_level),
    .rx_trig    (rx_trig),
    .rx_err_evt (rx_err_evt),
    .tx_start   (tx_start),
    .irq_txe    (irq_txe),
    .irq_rxf    (irq_rxf),
    .irq_rxerr  (irq_rxerr),
    .irq_brk    (irq_brk),
    .ctrl_q     (ctrl_q),
    .flags_q    (flags_q)
);

// File: tb/fifo_uart_irq_tb_top.sv
// Bench: a table of control values against a fixed set of flags, then
// directed tests for reset, clearing rules, thresholds and collisions.
module fifo_uart_irq_tb_top;
    localparam int CNT_W  = 5;
    localparam int IDLE_W = 8;
    localparam int NVEC   = 8;
    // {control value, expected {irq_txe, irq_rxf, irq_rxerr, irq_brk}}
    localparam logic [11:0] VEC [NVEC] = '{
        {8'h00, 4'b0000}, {8'h80, 4'b1000}, {8'h40, 4'b0111}, {8'h08, 4'b0011},
        {8'h48, 4'b0111}, {8'hC8, 4'b1111}, {8'h20, 4'b0000}, {8'hA0, 4'b1000}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic reg_sel = 0, reg_rd = 0, reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic tx_wr = 0, tx_pop = 0, rx_push = 0;
    logic [CNT_W-1:0] tx_level = 0, tx_trig = 0, rx_level = 0, rx_trig = 4;
    logic [IDLE_W-1:0] idle_limit = 5;
    logic rx_err_evt = 0, rx_brk_evt = 0, rx_ovr_evt = 0;
    logic tx_start, irq_txe, irq_rxf, irq_rxerr, irq_brk;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fifo_uart_irq #(.CNT_W(CNT_W), .IDLE_W(IDLE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_wr(tx_wr), .tx_pop(tx_pop), .tx_level(tx_level), .tx_trig(tx_trig),
        .rx_push(rx_push), .rx_level(rx_level), .rx_trig(rx_trig),
        .idle_limit(idle_limit), .rx_err_evt(rx_err_evt), .rx_brk_evt(rx_brk_evt),
        .rx_ovr_evt(rx_ovr_evt), .tx_start(tx_start), .irq_txe(irq_txe),
        .irq_rxf(irq_rxf), .irq_rxerr(irq_rxerr), .irq_brk(irq_brk)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr_reg(input logic sel, input logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1; step(); reg_wr = 0;
    endtask

    task automatic rd_stat();
        reg_sel = 1; reg_rd = 1; step(); reg_rd = 0;
    endtask

    function automatic logic [7:0] irqs();
        return {4'b0, irq_txe, irq_rxf, irq_rxerr, irq_brk};
    endfunction

    task automatic peek(input logic sel, output logic [7:0] d);
        reg_sel = sel; #1; d = reg_rdata;
    endtask

    task automatic clear_all();
        rd_stat(); wr_reg(1, 8'h00);
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) step();
        rst_n = 1;
        step();
        peek(0, d); check("R1 ctrl after reset", d, 8'h00);
        peek(1, d); check("R1 status after reset", d, 8'h00);
        check("R1 irqs after reset", irqs(), 8'h00);
        check("R1 tx_start after reset", {7'b0, tx_start}, 8'h00);

        // Set txe, rdf, er, brk for the enable table
        tx_level = 0; tx_trig = 0; tx_pop = 1; rx_level = 4;
        rx_err_evt = 1; rx_brk_evt = 1; step();
        tx_pop = 0; rx_err_evt = 0; rx_brk_evt = 0; rx_level = 0;
        peek(1, d); check("R2 status layout", d, 8'h3A);
        for (int i = 0; i < NVEC; i++) begin
            wr_reg(0, VEC[i][11:4]);
            check("R4/R5/R8 enable table", irqs(), {4'b0, VEC[i][3:0]});
        end

        // R9: bare write of 0 keeps flags
        wr_reg(1, 8'h00);
        peek(1, d); check("R9 write without read", d, 8'h3A);
        rd_stat(); wr_reg(1, 8'h20);
        peek(1, d); check("R9 write of 1 keeps flag", d, 8'h20);
        wr_reg(1, 8'h00);
        peek(1, d); check("R9 arm consumed by write", d, 8'h20);
        clear_all();
        peek(1, d); check("R9 read then write clears", d, 8'h00);

        // R3: trigger boundary
        wr_reg(0, 8'hC8);
        tx_trig = 4; tx_level = 6; tx_pop = 1; step(); tx_pop = 0;
        peek(1, d); check("R3 pop above trigger", d, 8'h00);
        tx_level = 4; tx_pop = 1; step(); tx_pop = 0;
        peek(1, d); check("R3 pop at trigger", d, 8'h20);
        check("R4 irq_txe with enable", {7'b0, irq_txe}, 8'h01);
        wr_reg(0, 8'h48);
        check("R4 irq_txe masked", {7'b0, irq_txe}, 8'h00);
        clear_all();

        // R10: set collides with a valid clear
        rx_err_evt = 1; step(); rx_err_evt = 0;
        rd_stat();
        rx_err_evt = 1; wr_reg(1, 8'h00); rx_err_evt = 0;
        peek(1, d); check("R10 set wins over clear", d, 8'h10);
        wr_reg(1, 8'h00);
        peek(1, d); check("R10 collision consumed arm", d, 8'h10);
        clear_all();
        peek(1, d); check("R10 later clear", d, 8'h00);

        // R7: data-ready timeout, R5 through data-ready
        rx_trig = 4; idle_limit = 5; rx_level = 1; rx_push = 1; step(); rx_push = 0;
        repeat (4) step();
        peek(1, d); check("R7 not yet idle", d & 8'h01, 8'h00);
        step();
        peek(1, d); check("R7 idle timeout", d & 8'h01, 8'h01);
        check("R5 irq_rxf from data-ready", {7'b0, irq_rxf}, 8'h01);
        rx_level = 0; clear_all();

        // R6: receive trigger boundary
        rx_level = 3; step();
        peek(1, d); check("R6 below trigger", d & 8'h02, 8'h00);
        rx_level = 4; step();
        peek(1, d); check("R6 at trigger", d & 8'h02, 8'h02);
        rx_level = 0; clear_all();

        // R8: overrun drives break request via error enable only
        wr_reg(0, 8'h08);
        rx_ovr_evt = 1; step(); rx_ovr_evt = 0;
        check("R8 overrun break request", irqs(), 8'h01);
        wr_reg(0, 8'h00);
        check("R8 both enables off", irqs(), 8'h00);
        clear_all();

        // R11: start gating
        tx_wr = 1; #1;
        check("R11 start blocked", {7'b0, tx_start}, 8'h00);
        tx_wr = 0;
        wr_reg(0, 8'h20);
        tx_wr = 1; #1;
        check("R11 start enabled", {7'b0, tx_start}, 8'h01);
        tx_wr = 0;

        // R2: unimplemented control bits
        wr_reg(0, 8'hFF);
        peek(0, d); check("R2 control mask", d, 8'hE8);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule